// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a run of bytes between memory and a peripheral data port for one DMA channel. A register front end supplies a source address, a destination address, an addressing mode for each side, a unit width and a byte count. A one-cycle start pulse launches the copy. Each unit is fetched with a single-beat read request and then stored with a single-beat write request. After every store the live byte count drops by the unit width, so software can read it at any moment as the residue still to move.

Each side steps its own address up or down by the unit width, or holds it. Holding suits a peripheral FIFO. A memory-to-peripheral copy uses an incrementing source and a held destination. A peripheral-to-memory copy is the reverse. The channel signals completion with a done pulse. An abort pulse stops a transfer at once and raises the abort indication together with done, so completion logic sees one event whichever way the transfer ended.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `rd_req_o`, `wr_req_o`, `done_o` and `abort_o` are low and `residue_o` is 0.
- R2: A start sampled in idle with a nonzero size, and no abort, loads the configuration. From the next cycle `rd_req_o` is high with `rd_addr_o` equal to the source address and `unit_o` equal to the unit code. Unit code 0, 1, 2 or 3 means 1, 2, 3 or 4 bytes.
- R3: Each unit is read and then written. `rd_req_o` stays high until `rd_ack_i`. In the next cycle `wr_req_o` rises, with `wr_data_o` equal to the `rd_data_i` sampled at that acknowledge and `wr_addr_o` equal to the current destination address.
- R4: Each side has a 2-bit mode: 0 adds the unit byte count to the address after each write acknowledge, 1 subtracts it, and 2 or 3 holds the address.
- R5: On each `wr_ack_i`, `residue_o` drops by the unit byte count. When no more than one unit remains, it drops to 0.
- R6: When the residue reaches 0, `done_o` is high for exactly the next cycle with `abort_o` low, and the channel is idle after that.
- R7: A start with size 0 raises `done_o` in the next cycle and issues no read or write request.
- R8: A start while the channel is busy has no effect on addresses, residue or requests.
- R9: An abort while busy drops both requests in the next cycle and raises `done_o` and `abort_o` together for one cycle. `residue_o` keeps the bytes not yet written.
- R10: An abort in idle raises `done_o` and `abort_o` together in the next cycle.
- R11: When abort and start arrive together in idle, the abort wins: no request is issued and the residue is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| unit_i | input | 2 | Unit width code (bytes minus one) |
| src_addr_i | input | 32 | Source start address |
| dst_addr_i | input | 32 | Destination start address |
| size_i | input | 32 | Byte count |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| unit_o | output | 2 | Unit width code of the transfer |
| residue_o | output | 32 | Bytes still to move |
| busy_o | output | 1 | Channel active |
| done_o | output | 1 | Completion pulse |
| abort_o | output | 1 | Abort indication, only together with done |

## Verification
Every result falls due exactly one cycle after the stimulus that causes it:
- the read request after a start;
- the write request and data after a read acknowledge;
- the new residue and address after a write acknowledge;
- done and abort after the final acknowledge or after an abort pulse.

The bench changes inputs on falling edges and holds each for one rising edge. It reads the outputs on the following falling edge, which is the cycle the result is due. The bench keeps its own model of the addresses and residue and advances it by the unit width at each acknowledge, so every beat is checked at the cycle it lands.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FINISH = 2'd3
  } chan_state_e;

  typedef enum logic [1:0] {
    AM_INC  = 2'd0,
    AM_DEC  = 2'd1,
    AM_HOLD = 2'd2,
    AM_RSVD = 2'd3
  } addr_mode_e;

  // unit code is bytes minus one
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

endpackage

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          step_i,
  input  logic [2:0]    bytes_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_d;
  addr_mode_e    mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_q;
    if (load_i) begin
      addr_d = addr_i;
      mode_d = addr_mode_e'(mode_i);
    end else if (step_i) begin
      unique case (mode_q)
        AM_INC:  addr_d = addr_q + AW'(bytes_i);
        AM_DEC:  addr_d = addr_q - AW'(bytes_i);
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= AM_INC;
    end else if (load_i || step_i) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr_o = addr_q;

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (mode_q == AM_HOLD || mode_q == AM_RSVD)) |=> $stable(addr_o));

  // R4
  inc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && mode_q == AM_INC) |=> (addr_o == $past(addr_o) + AW'($past(bytes_i))));

endmodule

// File: rtl/dmac_size_cnt.sv
module dmac_size_cnt #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [SW-1:0] size_i,
  input  logic          step_i,
  input  logic [2:0]    bytes_i,
  output logic          last_o,
  output logic [SW-1:0] res_o
);

  logic [SW-1:0] res_q, res_d;
  logic          last;

  assign last = (res_q <= SW'(bytes_i));

  always_comb begin
    res_d = res_q;
    if (load_i)      res_d = size_i;
    else if (step_i) res_d = last ? '0 : res_q - SW'(bytes_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                res_q <= '0;
    else if (load_i || step_i) res_q <= res_d;
  end

  assign last_o = last;
  assign res_o  = res_q;

  // R5
  res_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && res_q != '0) |=> (res_o < $past(res_o)));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        size_zero_i,
  input  logic        last_i,
  input  logic        rd_ack_i,
  input  logic        wr_ack_i,
  output chan_state_e state_o,
  output logic        load_o,
  output logic        step_o,
  output logic        capture_o,
  output logic        done_o,
  output logic        abort_o
);

  chan_state_e state_q, state_d;
  logic        abt_q, abt_d;

  always_comb begin
    state_d   = state_q;
    abt_d     = abt_q;
    load_o    = 1'b0;
    step_o    = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (abort_i) begin
          state_d = ST_FINISH;
          abt_d   = 1'b1;
        end else if (start_i) begin
          load_o  = 1'b1;
          abt_d   = 1'b0;
          state_d = size_zero_i ? ST_FINISH : ST_READ;
        end
      end
      ST_READ: begin
        if (abort_i) begin
          state_d = ST_FINISH;
          abt_d   = 1'b1;
        end else if (rd_ack_i) begin
          capture_o = 1'b1;
          state_d   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        step_o = wr_ack_i;
        if (abort_i) begin
          state_d = ST_FINISH;
          abt_d   = 1'b1;
        end else if (wr_ack_i) begin
          state_d = last_i ? ST_FINISH : ST_READ;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      abt_q   <= abt_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = (state_q == ST_FINISH);
  assign abort_o = (state_q == ST_FINISH) && abt_q;

  // R9
  abort_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> done_o);

  // R9
  busy_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && (state_q == ST_READ || state_q == ST_WRITE)) |=> (done_o && abort_o));

  // R10
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && state_q == ST_IDLE) |=> abort_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [1:0]    unit_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [SW-1:0] size_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic [1:0]    unit_o,
  output logic [SW-1:0] residue_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_o
);

  localparam int NSIDE = 2;

  chan_state_e   state;
  logic          load, step, capture, last;
  logic [1:0]    unit_q;
  logic [2:0]    bytes;
  logic [DW-1:0] dbuf_q;

  logic [1:0]    side_mode [NSIDE];
  logic [AW-1:0] side_addr [NSIDE];
  logic [AW-1:0] side_cur  [NSIDE];

  assign side_mode[0] = src_mode_i;
  assign side_mode[1] = dst_mode_i;
  assign side_addr[0] = src_addr_i;
  assign side_addr[1] = dst_addr_i;

  assign bytes = unit_bytes(unit_q);

  dmac_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .size_zero_i (size_i == '0),
    .last_i      (last),
    .rd_ack_i    (rd_ack_i),
    .wr_ack_i    (wr_ack_i),
    .state_o     (state),
    .load_o      (load),
    .step_o      (step),
    .capture_o   (capture),
    .done_o      (done_o),
    .abort_o     (abort_o)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dmac_addr_gen #(.AW(AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .mode_i  (side_mode[g]),
      .addr_i  (side_addr[g]),
      .step_i  (step),
      .bytes_i (bytes),
      .addr_o  (side_cur[g])
    );
  end

  dmac_size_cnt #(.SW(SW)) u_size (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .size_i  (size_i),
    .step_i  (step),
    .bytes_i (bytes),
    .last_o  (last),
    .res_o   (residue_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    unit_q <= '0;
    else if (load) unit_q <= unit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbuf_q <= '0;
    else if (capture) dbuf_q <= rd_data_i;
  end

  assign rd_req_o  = (state == ST_READ);
  assign wr_req_o  = (state == ST_WRITE);
  assign rd_addr_o = side_cur[0];
  assign wr_addr_o = side_cur[1];
  assign wr_data_o = dbuf_q;
  assign unit_o    = unit_q;
  assign busy_o    = (state != ST_IDLE);

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_o) |-> ($past(rd_ack_i) && wr_data_o == $past(rd_data_i)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);

  // R8
  busy_start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && start_i && !abort_i && !rd_ack_i) |=> ($stable(rd_addr_o) && $stable(residue_o)));

  // R7
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !abort_i && size_i == '0) |=> (done_o && !rd_req_o && !wr_req_o));

endmodule

// File: tb/sim_dma_xfer_chan.sv
module sim_dma_xfer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0;
  logic [1:0]  src_mode_i = '0, dst_mode_i = '0, unit_i = '0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0, size_i = '0;
  logic        rd_ack_i = 1'b0, wr_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_req_o, wr_req_o, busy_o, done_o, abort_o;
  logic [31:0] rd_addr_o, wr_addr_o, wr_data_o, residue_o;
  logic [1:0]  unit_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] e_src, e_dst, e_res;
  logic [1:0]  e_sm, e_dm, e_unit;

  always #4 clk = ~clk;

  dma_xfer_chan u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i), .unit_i(unit_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .size_i(size_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .unit_o(unit_o),
    .residue_o(residue_o), .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o)
  );

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [1:0]  unit;
    logic [7:0]  size;
    logic [31:0] src;
    logic [31:0] dst;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd2, 2'd3, 8'd12, 32'h0000_1000, 32'h8000_0000},
    '{2'd2, 2'd0, 2'd0, 8'd5,  32'h9000_0040, 32'h0000_2000},
    '{2'd1, 2'd1, 2'd1, 8'd6,  32'h0000_3010, 32'h0000_4010},
    '{2'd0, 2'd1, 2'd2, 8'd7,  32'h0000_5000, 32'h0000_6100},
    '{2'd3, 2'd3, 2'd3, 8'd3,  32'h0000_7000, 32'h0000_7800},
    '{2'd0, 2'd0, 2'd1, 8'd4,  32'hFFFF_FFFC, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] m, input logic [1:0] u);
    case (m)
      2'd0:    return a + 32'({1'b0, u} + 3'd1);
      2'd1:    return a - 32'({1'b0, u} + 3'd1);
      default: return a;
    endcase
  endfunction

  task automatic launch(input vec_t v);
    src_mode_i = v.sm; dst_mode_i = v.dm; unit_i = v.unit;
    size_i = 32'(v.size); src_addr_i = v.src; dst_addr_i = v.dst;
    e_sm = v.sm; e_dm = v.dm; e_unit = v.unit;
    e_src = v.src; e_dst = v.dst; e_res = 32'(v.size);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic beat(input logic [31:0] data);
    logic [31:0] nb;
    check("R2 rd_req", 32'(rd_req_o), 32'd1);
    check("R4 rd_addr", rd_addr_o, e_src);
    check("R2 unit", 32'(unit_o), 32'(e_unit));
    rd_data_i = data; rd_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0;
    check("R3 wr_req", {30'd0, rd_req_o, wr_req_o}, 32'd1);
    check("R4 wr_addr", wr_addr_o, e_dst);
    check("R3 wr_data", wr_data_o, data);
    wr_ack_i = 1'b1;
    @(negedge clk);
    wr_ack_i = 1'b0;
    nb = 32'({1'b0, e_unit} + 3'd1);
    e_res = (e_res <= nb) ? 32'd0 : e_res - nb;
    e_src = stepped(e_src, e_sm, e_unit);
    e_dst = stepped(e_dst, e_dm, e_unit);
    check("R5 residue", residue_o, e_res);
    if (e_res == 0) check("R6 done", {30'd0, done_o, abort_o}, 32'd2);
    else            check("R6 no early done", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {27'd0, busy_o, rd_req_o, wr_req_o, done_o, abort_o}, 32'd0);
    check("R1 residue", residue_o, 32'd0);

    // vector table: full transfers
    for (int v = 0; v < 6; v++) begin
      int n;
      launch(VECS[v]);
      n = 0;
      while (e_res != 0 && n < 64) begin
        beat(32'hA500_0000 | (32'(v) << 8) | 32'(n));
        n++;
      end
      @(negedge clk);
      check("R6 idle after", {30'd0, busy_o, done_o}, 32'd0);
    end

    // R7 zero size
    launch('{2'd0, 2'd2, 2'd0, 8'd0, 32'h100, 32'h200});
    check("R7 done", {29'd0, done_o, rd_req_o, abort_o}, 32'd4);
    @(negedge clk);
    check("R7 idle", {30'd0, busy_o, wr_req_o}, 32'd0);

    // R8 start while busy
    launch(VECS[0]);
    src_addr_i = 32'h0000_DEAD; size_i = 32'd40; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R8 rd_addr kept", rd_addr_o, 32'h0000_1000);
    check("R8 residue kept", residue_o, 32'd12);
    check("R8 still reading", 32'(rd_req_o), 32'd1);

    // R9 abort in read phase, after one beat
    beat(32'h1234_5678);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check("R9 read abort flags", {28'd0, done_o, abort_o, rd_req_o, wr_req_o}, 32'hC);
    check("R9 residue kept", residue_o, 32'd8);
    @(negedge clk);
    check("R9 idle", {30'd0, busy_o, done_o}, 32'd0);

    // R9 abort in write phase
    launch(VECS[0]);
    rd_data_i = 32'h5555_AAAA; rd_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0;
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check("R9 write abort flags", {28'd0, done_o, abort_o, rd_req_o, wr_req_o}, 32'hC);
    check("R9 write residue", residue_o, 32'd12);
    @(negedge clk);

    // R10 abort in idle
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check("R10 idle abort", {30'd0, done_o, abort_o}, 32'd3);
    @(negedge clk);

    // R11 abort beats start
    size_i = 32'd20; src_addr_i = 32'h0000_0F00; start_i = 1'b1; abort_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; abort_i = 1'b0;
    check("R11 flags", {29'd0, abort_o, rd_req_o, wr_req_o}, 32'd4);
    check("R11 residue not loaded", residue_o, 32'd12);
    @(negedge clk);
    check("R11 idle", 32'(busy_o), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule